// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Waveform Sequencer

This block produces the drive-level codes for the common and segment pins of a passive multiplexed LCD. Each phase tick advances it by one phase. Every phase selects one common. A frame is one pass over the active commons. Frames alternate between an odd and an even polarity, so that every pixel sees zero average voltage over a pair of frames.

Every output pin carries a small level code. The code indexes the voltage ladder of the chosen bias, and an analog stage outside this block turns it into a voltage. Optional dead-time phases can be placed between an odd frame and the even frame that follows it. During those phases every pin is held at ground, which lowers the contrast. The block also produces a high-drive enable for the resistor ladder. This enable is pulsed for a programmed number of clock cycles whenever any pin level changes, can be held on permanently, and is always suppressed when the output buffers are in use.

Top module: `lcd_wave_seq`

## Requirements
- R1: After reset the block is in phase 0 of an odd frame, so `frame_odd` is 1, and `hd_en` is 0 when `hd_perm` is 0.
- R2: A `phase_tick` advances the phase by one. After the last active phase, which is phase `duty_sel`, the next phase is phase 0 and the frame parity flips. This applies unless a dead time is due (R6). With no tick and no sync, the phase and the parity hold.
- R3: For an active common c, the code is the top level when c is the current phase in an odd frame. It is 0 when c is the current phase in an even frame. Otherwise it is 1 in an odd frame and top−1 in an even frame. The common is at `com_lvl[3c+2:3c]`.
- R4: Segment s reads pixel bit `pix[phase*NUM_SEG+s]`. In an odd frame a set bit gives 0 and a clear bit gives top−1. In an even frame a set bit gives top and a clear bit gives 1.
- R5: A common whose index is above `duty_sel` always shows code 0.
- R6: A nonzero `dead_len` inserts that many phases after each odd frame. In those phases every common and segment shows 0 and `frame_odd` stays 1. The phase that follows the dead time is phase 0 of an even frame. An even frame never leads into a dead time.
- R7: `sync_start` takes priority over `phase_tick` and puts the block in phase 0 of an odd frame.
- R8: When any pin code changes, `hd_en` is high for exactly `pon_len` clock cycles, starting with the cycle in which the change appears. A `pon_len` of 0 gives no pulse.
- R9: `hd_perm`=1 holds `hd_en` at 1.
- R10: `buf_en`=1 forces `hd_en` to 0, regardless of `hd_perm` and of any pulse in progress.
- R11: `bias_sel` sets the top level. A value of 0 or 3 gives 1/4 bias with top 4, 1 gives 1/2 bias with top 2, and 2 gives 1/3 bias with top 3. No pin code ever exceeds the top level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_tick | input | 1 | Advance one phase |
| sync_start | input | 1 | Restart at phase 0 of an odd frame |
| duty_sel | input | 3 | Number of active commons minus one |
| bias_sel | input | 2 | Bias select (R11) |
| dead_len | input | 3 | Dead-time phases after each odd frame |
| pon_len | input | 3 | High-drive pulse length in clock cycles |
| hd_perm | input | 1 | Hold high drive on |
| buf_en | input | 1 | Output buffers in use; suppresses high drive |
| pix | input | 64 | Displayed pixels, common-major |
| com_lvl | output | 24 | Level code per common, 3 bits each |
| seg_lvl | output | 24 | Level code per segment, 3 bits each |
| hd_en | output | 1 | High-drive enable for the resistor ladder |
| frame_odd | output | 1 | 1 in odd frames and in dead time |

## Verification
The bench uses the default build, which has 8 commons and 8 segments. With that build every duty from a single common up to all eight can be reached, and so can a duty that is shortened while the sequence sits in a higher phase. A random run keeps changing duty, bias, dead length, pixels and tick density. A bench model checks every pin code on every cycle, including the dead-time gaps that follow only odd frames. Directed sections then measure the exact length of the high-drive pulse, and check the permanent-on and buffer overrides.

// File: rtl/lcd_wave_seq.sv
module lcd_wave_seq #(
  parameter int NUM_COM = 8,
  parameter int NUM_SEG = 8,
  parameter int LVL_W   = 3,
  parameter int DEAD_W  = 3,
  parameter int PON_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       phase_tick,
  input  logic                       sync_start,
  input  logic [$clog2(NUM_COM)-1:0] duty_sel,
  input  logic [1:0]                 bias_sel,
  input  logic [DEAD_W-1:0]          dead_len,
  input  logic [PON_W-1:0]           pon_len,
  input  logic                       hd_perm,
  input  logic                       buf_en,
  input  logic [NUM_COM*NUM_SEG-1:0] pix,
  output logic [NUM_COM*LVL_W-1:0]   com_lvl,
  output logic [NUM_SEG*LVL_W-1:0]   seg_lvl,
  output logic                       hd_en,
  output logic                       frame_odd
);
  localparam int PH_W  = $clog2(NUM_COM);
  localparam int OUT_W = (NUM_COM + NUM_SEG) * LVL_W;

  logic [PH_W-1:0]   phase_q;
  logic              odd_q, dead_q;
  logic [DEAD_W-1:0] dcnt_q;
  logic [LVL_W-1:0]  top, lo_mid, hi_mid;

  always_comb begin
    case (bias_sel)
      2'd1:    top = LVL_W'(2);
      2'd2:    top = LVL_W'(3);
      default: top = LVL_W'(4);
    endcase
  end
  assign lo_mid = LVL_W'(1);
  assign hi_mid = top - LVL_W'(1);

  wire last_ph  = (phase_q >= duty_sel);
  wire dead_end = ({1'b0, dcnt_q} + 1'b1) >= {1'b0, dead_len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      odd_q   <= 1'b1;
      dead_q  <= 1'b0;
      dcnt_q  <= '0;
    end else if (sync_start) begin
      phase_q <= '0;
      odd_q   <= 1'b1;
      dead_q  <= 1'b0;
      dcnt_q  <= '0;
    end else if (phase_tick) begin
      if (dead_q) begin
        if (dead_end) begin
          dead_q <= 1'b0;
          odd_q  <= 1'b0;
        end
        dcnt_q <= dcnt_q + 1'b1;
      end else if (last_ph) begin
        phase_q <= '0;
        dcnt_q  <= '0;
        if (odd_q && dead_len != '0) dead_q <= 1'b1;
        else                         odd_q  <= ~odd_q;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign frame_odd = odd_q;

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    always_comb begin
      if (dead_q || PH_W'(c) > duty_sel)
        com_lvl[c*LVL_W +: LVL_W] = '0;
      else if (PH_W'(c) == phase_q)
        com_lvl[c*LVL_W +: LVL_W] = odd_q ? top : '0;
      else
        com_lvl[c*LVL_W +: LVL_W] = odd_q ? lo_mid : hi_mid;
    end
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    wire on = pix[int'(phase_q) * NUM_SEG + s];
    always_comb begin
      if (dead_q)
        seg_lvl[s*LVL_W +: LVL_W] = '0;
      else if (odd_q)
        seg_lvl[s*LVL_W +: LVL_W] = on ? '0 : hi_mid;
      else
        seg_lvl[s*LVL_W +: LVL_W] = on ? top : lo_mid;
    end
  end

  logic [OUT_W-1:0] out_q;
  logic             prev_vld;
  logic [PON_W-1:0] pon_cnt;
  wire  [OUT_W-1:0] out_now = {com_lvl, seg_lvl};
  wire              changed = prev_vld && (out_now != out_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q    <= '0;
      prev_vld <= 1'b0;
      pon_cnt  <= '0;
    end else begin
      out_q    <= out_now;
      prev_vld <= 1'b1;
      if (changed && pon_len != '0) pon_cnt <= pon_len - 1'b1;
      else if (pon_cnt != '0)       pon_cnt <= pon_cnt - 1'b1;
    end
  end

  assign hd_en = !buf_en && (hd_perm || (changed && pon_len != '0) || pon_cnt != '0);
endmodule

// File: rtl/lcd_wave_seq_chk.sv
module lcd_wave_seq_chk #(
  parameter int NUM_SEG = 8,
  parameter int LVL_W   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     phase_tick,
  input logic                     sync_start,
  input logic [1:0]               bias_sel,
  input logic                     hd_perm,
  input logic                     buf_en,
  input logic [NUM_SEG*LVL_W-1:0] seg_lvl,
  input logic                     hd_en,
  input logic                     frame_odd
);
  logic [LVL_W-1:0] top_c;
  assign top_c = (bias_sel == 2'd1) ? LVL_W'(2) : (bias_sel == 2'd2) ? LVL_W'(3) : LVL_W'(4);

  a_r10_buf_blocks_hd: assert property (@(posedge clk) disable iff (!rst_n)
    buf_en |-> !hd_en);

  a_r9_perm_hd: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_en && hd_perm) |-> hd_en);

  a_r2_parity_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_tick && !sync_start) |=> $stable(frame_odd));

  a_r7_sync_odd: assert property (@(posedge clk) disable iff (!rst_n)
    sync_start |=> frame_odd);

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_rng
    a_r11_seg_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      seg_lvl[s*LVL_W +: LVL_W] <= top_c);
  end
endmodule

bind lcd_wave_seq lcd_wave_seq_chk #(.NUM_SEG(NUM_SEG), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase_tick(phase_tick), .sync_start(sync_start),
  .bias_sel(bias_sel), .hd_perm(hd_perm), .buf_en(buf_en), .seg_lvl(seg_lvl),
  .hd_en(hd_en), .frame_odd(frame_odd));

// File: tb/lcd_wave_seq_test.sv
module lcd_wave_seq_test;
  localparam int NC = 8, NS = 8;
  logic clk = 0, rst_n = 0;
  logic phase_tick = 0, sync_start = 0, hd_perm = 0, buf_en = 0;
  logic [2:0] duty_sel = 3'd3, dead_len = 0, pon_len = 0;
  logic [1:0] bias_sel = 0;
  logic [NC*NS-1:0] pix = '0;
  logic [NC*3-1:0] com_lvl;
  logic [NS*3-1:0] seg_lvl;
  logic hd_en, frame_odd;

  int checks = 0, fails = 0, cyc = 0;
  int m_ph = 0, m_dc = 0;
  bit m_odd = 1, m_dead = 0;

  lcd_wave_seq uut (.clk(clk), .rst_n(rst_n), .phase_tick(phase_tick), .sync_start(sync_start),
    .duty_sel(duty_sel), .bias_sel(bias_sel), .dead_len(dead_len), .pon_len(pon_len),
    .hd_perm(hd_perm), .buf_en(buf_en), .pix(pix), .com_lvl(com_lvl), .seg_lvl(seg_lvl),
    .hd_en(hd_en), .frame_odd(frame_odd));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int top_of(input logic [1:0] b);
    return (b == 2'd1) ? 2 : (b == 2'd2) ? 3 : 4;
  endfunction

  function automatic int exp_com(input int c);
    int t = top_of(bias_sel);
    if (m_dead || c > int'(duty_sel)) return 0;
    if (c == m_ph) return m_odd ? t : 0;
    return m_odd ? 1 : t - 1;
  endfunction

  function automatic int exp_seg(input int s);
    int t = top_of(bias_sel);
    bit on = pix[m_ph*NS + s];
    if (m_dead) return 0;
    if (m_odd) return on ? 0 : t - 1;
    return on ? t : 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_pins();
    for (int c = 0; c < NC; c++)
      chk(m_dead ? "R6 common" : (c > int'(duty_sel)) ? "R5 unused common" : "R3 common",
          int'(com_lvl[c*3 +: 3]), exp_com(c));
    for (int s = 0; s < NS; s++)
      chk(m_dead ? "R6 segment" : "R4 segment", int'(seg_lvl[s*3 +: 3]), exp_seg(s));
    chk("R2 frame parity", int'(frame_odd), int'(m_odd));
  endtask

  task automatic model_edge();
    if (sync_start) begin
      m_ph = 0; m_odd = 1; m_dead = 0; m_dc = 0;
    end else if (phase_tick) begin
      if (m_dead) begin
        m_dc++;
        if (m_dc >= int'(dead_len)) begin m_dead = 0; m_odd = 0; end
      end else if (m_ph >= int'(duty_sel)) begin
        m_ph = 0; m_dc = 0;
        if (m_odd && dead_len != 0) m_dead = 1;
        else m_odd = !m_odd;
      end else m_ph++;
    end
  endtask

  task automatic step(input bit tick, input bit sync);
    @(negedge clk);
    phase_tick = tick; sync_start = sync;
    model_edge();
    @(negedge clk);
    phase_tick = 0; sync_start = 0;
    #1;
  endtask

  initial begin
    void'($urandom(32'h1c0de5));
    #12 rst_n = 1;
    @(negedge clk); #1;
    chk("R1 reset parity", int'(frame_odd), 1);
    chk("R1 reset hd", int'(hd_en), 0);
    check_pins();

    // R11 bias encodings: odd frame, phase 0, duty 4
    bias_sel = 2'd1; #1;
    chk("R11 half bias top", int'(com_lvl[2:0]), 2);
    chk("R11 half bias mid", int'(com_lvl[5:3]), 1);
    bias_sel = 2'd2; #1;
    chk("R11 third bias top", int'(com_lvl[2:0]), 3);
    bias_sel = 2'd3; #1;
    chk("R11 code 3 top", int'(com_lvl[2:0]), 4);

    // R6 directed: duty 2, dead 2
    duty_sel = 3'd1; dead_len = 3'd2; bias_sel = 0; pix = {NC{8'hA5}};
    step(1, 0); check_pins();
    step(1, 0); check_pins();
    chk("R6 dead holds odd", int'(frame_odd), 1);
    chk("R6 dead all vss", int'(com_lvl[2:0]), 0);
    step(1, 0); check_pins();
    step(1, 0); check_pins();
    chk("R6 even after dead", int'(frame_odd), 0);
    chk("R6 even selected com", int'(com_lvl[2:0]), 0);
    step(1, 0); step(1, 0); check_pins();
    chk("R6 no dead after even", int'(frame_odd), 1);

    // R7 sync
    step(1, 0);
    step(1, 1); check_pins();
    chk("R7 sync odd phase0", int'(com_lvl[2:0]), 4);

    // R8 pulse length
    duty_sel = 3'd3; dead_len = 0; pon_len = 3'd3;
    repeat (6) @(negedge clk);
    #1 chk("R8 idle no pulse", int'(hd_en), 0);
    @(negedge clk); phase_tick = 1; model_edge();
    @(negedge clk); phase_tick = 0; #1;
    chk("R8 pulse c0", int'(hd_en), 1);
    @(negedge clk); #1 chk("R8 pulse c1", int'(hd_en), 1);
    @(negedge clk); #1 chk("R8 pulse c2", int'(hd_en), 1);
    @(negedge clk); #1 chk("R8 pulse ends", int'(hd_en), 0);
    pon_len = 0;
    step(1, 0); chk("R8 pon zero", int'(hd_en), 0);
    hd_perm = 1; #1 chk("R9 perm", int'(hd_en), 1);
    buf_en = 1; #1 chk("R10 buf wins perm", int'(hd_en), 0);
    hd_perm = 0; pon_len = 3'd5;
    step(1, 0); chk("R10 buf blocks pulse", int'(hd_en), 0);
    buf_en = 0; pon_len = 0;
    repeat (8) @(negedge clk);

    // random mix
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 99) < 3) begin
        duty_sel = 3'($urandom_range(0, 7));
        bias_sel = 2'($urandom_range(0, 3));
        dead_len = 3'($urandom_range(0, 3));
      end
      if ($urandom_range(0, 99) < 10) pix = {$urandom(), $urandom()};
      phase_tick = ($urandom_range(0, 99) < 40);
      sync_start = ($urandom_range(0, 999) < 5);
      #1;
      check_pins();
      chk("R8 no pulse with pon 0", int'(hd_en), 0);
      model_edge();
    end
    @(negedge clk); phase_tick = 0; sync_start = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule